// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Strobe Controller

This block sits between an internal clocked request bus and an external asynchronous static RAM of 2^18 bytes. It accepts one single-beat read or write at a time through a request/ready handshake. It then plays the access out on the memory pins: two select lines of opposite polarity, a read-enable, a write-enable, the 18-bit address and the shared 8-bit data bus. Each phase is held long enough to meet the memory's access, pulse-width, setup and turnaround limits at the chosen clock period.

All timing limits are given as nanosecond parameters together with the clock period. The per-phase wait counts are derived from them by rounding up, so the same RTL serves any speed grade and clock. The defaults describe a 10 ns clock and a 70 ns grade. With these defaults a read holds the enables for 7 cycles, a write-enable pulse lasts 5 cycles, and the idle gap after a read is 3 cycles. Read data comes back on `rdata` with a one-cycle `rvalid` pulse. The controller drives the data bus only while it is writing.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and whenever `ready` is 1, the memory is parked deselected: `mem_sel_n`=1, `mem_sel`=0, `mem_rd_en_n`=1, `mem_wr_en_n`=1, and `rvalid`=0.
- R2: `ready` is 1 only when no access is in flight. A request is taken on a rising edge where `req`=1 and `ready`=1. With defaults, a write keeps `ready` low for 7 cycles after that edge.
- R3: A read (`req_we`=0) selects the memory with `mem_rd_en_n`=0 and `mem_wr_en_n`=1 for RD cycles. RD is the largest of the cycle-rounded cycle time, address access time and read-enable access time, which is 7 with defaults. The byte on `mem_dq` is captured at the end of the last of these cycles. `rvalid` is 1 for exactly one cycle, 7 edges after acceptance, with that byte on `rdata`.
- R4: A write (`req_wdata` stored when `req_we`=1) starts with one selected cycle with write-enable high. It then holds `mem_wr_en_n`=0 for WP cycles, which is 5 with defaults: the largest of the rounded pulse width, rounded data setup, and rounded address-to-end time minus one. It ends with at least one recovery cycle that is still selected but has write-enable high. This gives at least 6 selected cycles before the write-enable rises.
- R5: `mem_addr` takes the request address on acceptance and does not change while the memory is selected.
- R6: The controller drives `mem_dq` only in the write-enable-low and recovery phases. The driven byte is stable for the whole pulse, which covers at least 3 cycles before write-enable rises, and it is the requested byte.
- R7: The two selects always agree (`mem_sel_n` = not `mem_sel`). Read-enable and write-enable are never low together, and write-enable is never low while deselected.
- R8: After a read, all strobes stay idle and `ready` stays low for TURN cycles, which is 3 with defaults (the rounded read-disable float time). Only then can another access start, so a following write never drives the bus while the memory may still drive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Request byte address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Controller idle, request may be taken |
| rvalid | output | 1 | One-cycle read-data valid pulse |
| rdata | output | 8 | Read byte |
| mem_addr | output | 18 | Memory address |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_rd_en_n | output | 1 | Active-low read (output) enable |
| mem_wr_en_n | output | 1 | Active-low write enable |
| mem_dq | inout | 8 | Bidirectional memory data |

## Verification
The bench goes after a read that captures a cycle early. Its memory model drives a wrong byte until the full access time has passed, so an early capture returns corrupt data. It also issues a write straight after a read. The model keeps driving the bus for a short time after read-enable rises, so a controller with a missing or short idle gap shows up as bus contention. The model measures the write-enable pulse, the selected time before write end, data stability and address stability, so a pulse that is too short, a missing setup or recovery cycle, or a moving address each gets flagged. Address and data extremes and an overwrite of the same location check that the correct byte lands and comes back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_TURN,
      ST_WSET,
      ST_WPUL,
      ST_WREC
   } sram_st_e;

   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_fsm.sv
module sram_strobe_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int RD_CYC   = 7,
   parameter int WP_CYC   = 5,
   parameter int REC_CYC  = 1,
   parameter int TURN_CYC = 3,
   parameter int CNT_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              ready,
   output logic              accept,
   output logic              rd_last,
   output logic              dq_drive,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              sel_n,
   output logic              sel,
   output logic              rd_en_n,
   output logic              wr_en_n
);

   sram_st_e         st_q, st_d;
   logic             ld;
   logic [CNT_W-1:0] ld_val;
   logic             tmr_done;
   logic             selected;

   sram_phase_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .done     (tmr_done)
   );

   always_comb begin
      st_d   = st_q;
      ld     = 1'b0;
      ld_val = '0;
      unique case (st_q)
         ST_IDLE: if (req) begin
            ld = 1'b1;
            if (req_we) begin
               st_d = ST_WSET;
            end else begin
               st_d   = ST_RD;
               ld_val = CNT_W'(RD_CYC - 1);
            end
         end
         ST_RD: if (tmr_done) begin
            st_d   = ST_TURN;
            ld     = 1'b1;
            ld_val = CNT_W'(TURN_CYC - 1);
         end
         ST_TURN: if (tmr_done) st_d = ST_IDLE;
         ST_WSET: begin
            st_d   = ST_WPUL;
            ld     = 1'b1;
            ld_val = CNT_W'(WP_CYC - 1);
         end
         ST_WPUL: if (tmr_done) begin
            st_d   = ST_WREC;
            ld     = 1'b1;
            ld_val = CNT_W'(REC_CYC - 1);
         end
         ST_WREC: if (tmr_done) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         mem_addr <= '0;
      end else begin
         st_q <= st_d;
         if (accept) mem_addr <= req_addr;
      end
   end

   assign ready    = (st_q == ST_IDLE);
   assign accept   = ready && req;
   assign rd_last  = (st_q == ST_RD) && tmr_done;
   assign selected = (st_q == ST_RD) || (st_q == ST_WSET) ||
                     (st_q == ST_WPUL) || (st_q == ST_WREC);
   assign sel_n    = !selected;
   assign sel      = selected;
   assign rd_en_n  = (st_q != ST_RD);
   assign wr_en_n  = (st_q != ST_WPUL);
   assign dq_drive = (st_q == ST_WPUL) || (st_q == ST_WREC);

   // R7
   oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_en_n && !wr_en_n));

   // R5
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && $past(!sel_n)) |-> $stable(mem_addr));

   // R4
   we_end_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_en_n) |-> (!sel_n && sel));

   // R8
   turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_en_n) |-> (!ready && sel_n && wr_en_n));

endmodule

// File: rtl/sram_dbus.sv
module sram_dbus #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic              drive,
   input  logic              capture,
   inout  wire  [DATA_W-1:0] dq,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   logic [DATA_W-1:0] wd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_q   <= '0;
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         if (accept)  wd_q  <= wdata_in;
         if (capture) rdata <= dq;
         rvalid <= capture;
      end
   end

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_pad
      assign dq[gi] = drive ? wd_q[gi] : 1'bz;
   end

   // R3
   rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |=> !rvalid);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int DATA_W   = 8,
   parameter int CLK_NS   = 10,
   parameter int T_RC_NS  = 70,
   parameter int T_AA_NS  = 70,
   parameter int T_OE_NS  = 40,
   parameter int T_WP_NS  = 50,
   parameter int T_AW_NS  = 60,
   parameter int T_DW_NS  = 30,
   parameter int T_WC_NS  = 70,
   parameter int T_OHZ_NS = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ready,
   output logic              rvalid,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel_n,
   output logic              mem_sel,
   output logic              mem_rd_en_n,
   output logic              mem_wr_en_n,
   inout  wire  [DATA_W-1:0] mem_dq
);

   localparam int RD_CYC   = max_of(ns_to_cyc(T_RC_NS, CLK_NS),
                             max_of(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)));
   localparam int WP_CYC   = max_of(ns_to_cyc(T_WP_NS, CLK_NS),
                             max_of(ns_to_cyc(T_DW_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS) - 1));
   localparam int REC_CYC  = max_of(1, ns_to_cyc(T_WC_NS, CLK_NS) - 1 - WP_CYC);
   localparam int TURN_CYC = max_of(1, ns_to_cyc(T_OHZ_NS, CLK_NS));
   localparam int MAX_CYC  = max_of(max_of(RD_CYC, WP_CYC), max_of(REC_CYC, TURN_CYC));
   localparam int CNT_W    = $clog2(MAX_CYC + 1);

   initial begin : prm_chk
      assert (CLK_NS > 0) else $error("clock period must be positive");
      assert (ADDR_W > 0 && DATA_W > 0) else $error("bus widths must be positive");
      assert (RD_CYC >= 1 && WP_CYC >= 1) else $error("phase counts must be at least one");
   end

   logic accept, rd_last, dq_drive;

   sram_strobe_fsm #(
      .ADDR_W   (ADDR_W),
      .RD_CYC   (RD_CYC),
      .WP_CYC   (WP_CYC),
      .REC_CYC  (REC_CYC),
      .TURN_CYC (TURN_CYC),
      .CNT_W    (CNT_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .req_we   (req_we),
      .req_addr (req_addr),
      .ready    (ready),
      .accept   (accept),
      .rd_last  (rd_last),
      .dq_drive (dq_drive),
      .mem_addr (mem_addr),
      .sel_n    (mem_sel_n),
      .sel      (mem_sel),
      .rd_en_n  (mem_rd_en_n),
      .wr_en_n  (mem_wr_en_n)
   );

   sram_dbus #(.DATA_W(DATA_W)) u_dbus (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .wdata_in (req_wdata),
      .drive    (dq_drive),
      .capture  (rd_last),
      .dq       (mem_dq),
      .rdata    (rdata),
      .rvalid   (rvalid)
   );

   // R1
   idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (mem_sel_n && !mem_sel && mem_rd_en_n && mem_wr_en_n && !rvalid));

   // R6
   drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_drive |-> (mem_rd_en_n && !mem_sel_n));

   // R7
   sel_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_sel_n == !mem_sel);

endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int RD   = 7;
   localparam int WP   = 5;
   localparam int DS   = 3;
   localparam int TURN = 3;
   localparam int WR_BUSY = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        req_we = 1'b0;
   logic [17:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        ready, rvalid;
   logic [7:0]  rdata;
   logic [17:0] mem_addr;
   logic        mem_sel_n, mem_sel, mem_rd_en_n, mem_wr_en_n;
   wire  [7:0]  dq;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_async_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
      .rvalid(rvalid), .rdata(rdata), .mem_addr(mem_addr),
      .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_rd_en_n(mem_rd_en_n),
      .mem_wr_en_n(mem_wr_en_n), .mem_dq(dq)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", rq, act, exp, $time);
      end
   endtask

   // ---------------- behavioural memory model ----------------
   logic [7:0]  mem_m [logic [17:0]];
   logic [7:0]  exp_m [logic [17:0]];
   logic        m_drv = 1'b0;
   logic [7:0]  m_val = '0;
   logic [17:0] sel_addr;
   logic [7:0]  dq_prev;
   int sel_cnt = 0, rd_cnt = 0, hold = 0, wl_cnt = 0, same = 0;
   logic we_prev = 1'b1;

   assign dq = m_drv ? m_val : 8'bz;

   function automatic logic [7:0] m_rd(input logic [17:0] a);
      return mem_m.exists(a) ? mem_m[a] : 8'h00;
   endfunction

   always @(negedge clk) begin
      logic sel_now, rd_act;
      if (rst_n) begin
         sel_now = !mem_sel_n && mem_sel;
         rd_act  = sel_now && !mem_rd_en_n && mem_wr_en_n;
         if (mem_sel_n == mem_sel)
            chk(1'b0, "R7 select pair", {mem_sel_n, mem_sel}, 2'b10);
         if (!sel_now) sel_cnt = 0;
         else begin
            if (sel_cnt == 0) sel_addr = mem_addr;
            else if (mem_addr != sel_addr)
               chk(1'b0, "R5 address moved", mem_addr, sel_addr);
            sel_cnt++;
         end
         rd_cnt = rd_act ? rd_cnt + 1 : 0;
         if (rd_act) hold = TURN + 1;
         else if (hold > 0) hold--;
         if (!mem_wr_en_n) begin
            if (wl_cnt == 0)
               chk(!m_drv, "R8 bus contention at write start", m_drv, 0);
            if (!sel_now) chk(1'b0, "R7 write while deselected", 0, 1);
            if (!mem_rd_en_n) chk(1'b0, "R7 read and write enables both low", 0, 1);
            if (wl_cnt == 0 || dq !== dq_prev) begin
               dq_prev = dq;
               same = 1;
            end else same++;
            wl_cnt++;
         end else if (!we_prev) begin
            chk(wl_cnt >= WP, "R4 write pulse cycles", wl_cnt, WP);
            chk(sel_now && sel_cnt - 1 >= WP + 1, "R4 select before write end", sel_cnt - 1, WP + 1);
            chk(same >= DS, "R6 data stable cycles", same, DS);
            mem_m[mem_addr] = dq_prev;
            wl_cnt = 0;
         end
         we_prev = mem_wr_en_n;
         m_drv = rd_act || hold > 0;
         m_val = (rd_act && rd_cnt >= RD) ? m_rd(mem_addr) : ~m_rd(mem_addr);
      end
   end

   // ---------------- watchdog ----------------
   always @(negedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // ---------------- request tasks ----------------
   task automatic issue(input bit w, input logic [17:0] a, input logic [7:0] d);
      int k = 0;
      while (!ready && k < 100) begin k++; @(negedge clk); end
      req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
      chk(mem_addr == a, "R5 address taken on accept", mem_addr, a);
   endtask

   task automatic do_write(input logic [17:0] a, input logic [7:0] d);
      int k = 0;
      issue(1'b1, a, d);
      while (!ready && k < 100) begin k++; @(negedge clk); end
      chk(k == WR_BUSY, "R2 write busy cycles", k, WR_BUSY);
      chk(mem_sel_n && !mem_sel && mem_rd_en_n && mem_wr_en_n, "R1 parked after write",
          {mem_sel_n, mem_sel, mem_rd_en_n, mem_wr_en_n}, 4'b1011);
      exp_m[a] = d;
   endtask

   task automatic do_read(input logic [17:0] a);
      int k = 0;
      int bz = 1;
      logic [7:0] e;
      e = exp_m.exists(a) ? exp_m[a] : 8'h00;
      issue(1'b0, a, 8'h00);
      k = 1;
      while (!rvalid && k < 100) begin k++; @(negedge clk); end
      chk(k == RD + 1, "R3 read latency", k - 1, RD);
      chk(rdata == e, "R3 read data", rdata, e);
      @(negedge clk);
      chk(!rvalid, "R3 rvalid single cycle", rvalid, 0);
      while (!ready && bz < 100) begin bz++; @(negedge clk); end
      chk(bz == TURN, "R8 idle gap after read", bz, TURN);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk(ready == 1'b1, "R1 ready in reset", ready, 1);
      chk(mem_sel_n && !mem_sel && mem_rd_en_n && mem_wr_en_n, "R1 strobes in reset",
          {mem_sel_n, mem_sel, mem_rd_en_n, mem_wr_en_n}, 4'b1011);
      chk(!rvalid, "R1 rvalid in reset", rvalid, 0);
   endtask

   task automatic t_basic();
      do_write(18'h00123, 8'h5A);
      do_write(18'h0ABCD, 8'hC3);
      do_read(18'h00123);
      do_read(18'h0ABCD);
   endtask

   task automatic t_extremes();
      do_write(18'h00000, 8'hFF);
      do_write(18'h3FFFF, 8'h00);
      do_read(18'h3FFFF);
      do_read(18'h00000);
   endtask

   task automatic t_overwrite();
      do_write(18'h15555, 8'h11);
      do_write(18'h15555, 8'hEE);
      do_read(18'h15555);
   endtask

   task automatic t_read_then_write();
      // R8: write right behind a read; the model keeps driving after read-enable rises
      do_read(18'h0ABCD);
      do_write(18'h2AAAA, 8'h96);
      do_read(18'h2AAAA);
      do_write(18'h2AAAA, 8'h69);
      do_read(18'h2AAAA);
   endtask

   task automatic t_ready_hold();
      // R2: request held high while busy is taken only once
      int k = 0;
      req = 1'b1; req_we = 1'b1; req_addr = 18'h01010; req_wdata = 8'h3C;
      @(posedge clk);
      @(negedge clk);
      req_addr = 18'h02020; req_wdata = 8'hA5;
      chk(!ready, "R2 ready low while in flight", ready, 0);
      while (!ready && k < 100) begin k++; @(negedge clk); end
      req = 1'b0;
      chk(k == WR_BUSY, "R2 busy with request held", k, WR_BUSY);
      exp_m[18'h01010] = 8'h3C;
      @(posedge clk);
      @(negedge clk);
      do_read(18'h01010);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_extremes();
      t_overwrite();
      t_read_then_write();
      t_ready_hold();
      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule